// File: doc/BRIEF.md
# Coprocessor Access Permission Checker

This block sits in the decode stage of a processor pipeline and judges every coprocessor instruction before it is issued. For each request it looks at the transfer class, the target coprocessor number, the register selector fields and whether the core is running privileged. It then decides whether the instruction may proceed or must be turned into an undefined-instruction trap.

Alongside the verdict it reports which register group the access targets. The groups are system control, performance monitor, clock/power/debug, DSP, or none. Later stages use this tag to steer the transfer.

The verdict and the tag are registered. They appear on the clock edge that follows the cycle in which the request strobe was high. In any cycle that follows a cycle without a strobe, all outputs read zero. The register files behind the coprocessors and the trap vectoring are outside this block.

Top module: `cpacc_gate`

## Requirements
- R1: Transfer class codes are MRC=0, MCR=1, LDC=2, STC=3, CDP=4, MRRC=5, MCRR=6, and 7 is reserved. MRC or MCR to coprocessor 15 in privileged mode is allowed, with tag 0 (system control).
- R2: Coprocessor 15 accessed from user mode, or by LDC or STC in any mode, raises undefined with tag 0.
- R3: MRC or MCR to coprocessor 14 in privileged mode is allowed. The tag for coprocessor 14 is 1 (performance monitor) when CRm is nonzero and 2 (clock/power/debug) when CRm is 0.
- R4: LDC or STC to coprocessor 14 in privileged mode is allowed when CRm is 0 (tag 2). It raises undefined when CRm is nonzero (tag 1).
- R5: Any coprocessor 14 access from user mode raises undefined.
- R6: CDP, MRRC and MCRR aimed at coprocessor 14 or 15 always raise undefined.
- R7: Coprocessor 0 allows MRC, MCR, MRRC and MCRR in either mode. It raises undefined for LDC, STC, CDP and the reserved class. Its tag is always 3 (DSP).
- R8: Any coprocessor number other than 0, 14 or 15 raises undefined with tag 7 (none). The reserved class 7 raises undefined on every coprocessor.
- R9: The verdict appears exactly one cycle after a strobe, with exactly one of allow and undefined high. One cycle after a cycle without a strobe, allow, undefined and the tag are all zero.
- R10: While reset is asserted, allow, undefined and the tag are zero.
- R11: The CRn field has no effect on the verdict or on the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe for a coprocessor instruction |
| req_op | input | 3 | Transfer class code (see R1) |
| req_cpnum | input | 4 | Target coprocessor number |
| req_crn | input | 4 | CRn register selector |
| req_crm | input | 4 | CRm register selector |
| req_priv | input | 1 | 1 when the core is in a privileged mode |
| rsp_allow | output | 1 | Registered: instruction may proceed |
| rsp_undef | output | 1 | Registered: raise undefined-instruction trap |
| rsp_tag | output | 3 | Registered register-group tag |

## Verification
One instruction can fall under two rejection rules in the same cycle. A user-mode LDC to coprocessor 14 with a nonzero CRm breaks both the privilege rule and the performance-monitor load/store block. The bench provokes this overlap and expects undefined together with the performance-monitor tag, which confirms that classification and permission act together.

A second overlap comes from strobes issued on consecutive cycles. There, the previous verdict must be replaced by a new one on the same edge that would otherwise clear the outputs. The bench drives back-to-back requests with opposite verdicts and then an idle cycle, and checks each cycle in turn.

// File: rtl/cpacc_pkg.sv
package cpacc_pkg;

  typedef enum logic [2:0] {
    OP_MRC  = 3'd0,
    OP_MCR  = 3'd1,
    OP_LDC  = 3'd2,
    OP_STC  = 3'd3,
    OP_CDP  = 3'd4,
    OP_MRRC = 3'd5,
    OP_MCRR = 3'd6,
    OP_RSVD = 3'd7
  } cp_op_e;

  typedef enum logic [2:0] {
    TAG_SYS  = 3'd0,
    TAG_PMU  = 3'd1,
    TAG_CPD  = 3'd2,
    TAG_DSP  = 3'd3,
    TAG_NONE = 3'd7
  } reg_tag_e;

  typedef struct packed {
    logic     allow;
    logic     undef;
    reg_tag_e tag;
  } verdict_t;

endpackage

// File: rtl/cpacc_classify.sv
module cpacc_classify
  import cpacc_pkg::*;
#(
  parameter int CP_W   = 4,
  parameter int CRM_W  = 4,
  parameter int SYS_CP = 15,
  parameter int DBG_CP = 14,
  parameter int DSP_CP = 0
) (
  input  logic [CP_W-1:0]  cpnum,
  input  logic [CRM_W-1:0] crm,
  output reg_tag_e         tag
);

  localparam logic [CP_W-1:0] SYS_ID = CP_W'(SYS_CP);
  localparam logic [CP_W-1:0] DBG_ID = CP_W'(DBG_CP);
  localparam logic [CP_W-1:0] DSP_ID = CP_W'(DSP_CP);

  always_comb begin
    tag = TAG_NONE;
    if (cpnum == SYS_ID) begin
      tag = TAG_SYS;
    end else if (cpnum == DBG_ID) begin
      tag = (crm != '0) ? TAG_PMU : TAG_CPD;
    end else if (cpnum == DSP_ID) begin
      tag = TAG_DSP;
    end
  end

endmodule

// File: rtl/cpacc_rules.sv
module cpacc_rules
  import cpacc_pkg::*;
(
  input  cp_op_e   op,
  input  reg_tag_e tag,
  input  logic     priv,
  output logic     allow
);

  logic is_xfer;
  logic is_mem;
  logic is_dual;

  always_comb begin
    is_xfer = (op == OP_MRC)  || (op == OP_MCR);
    is_mem  = (op == OP_LDC)  || (op == OP_STC);
    is_dual = (op == OP_MRRC) || (op == OP_MCRR);
  end

  always_comb begin
    unique case (tag)
      TAG_SYS: allow = priv && is_xfer;
      TAG_PMU: allow = priv && is_xfer;
      TAG_CPD: allow = priv && (is_xfer || is_mem);
      TAG_DSP: allow = is_xfer || is_dual;
      default: allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/cpacc_gate.sv
module cpacc_gate
  import cpacc_pkg::*;
#(
  parameter int CP_W   = 4,
  parameter int CRN_W  = 4,
  parameter int CRM_W  = 4,
  parameter int SYS_CP = 15,
  parameter int DBG_CP = 14,
  parameter int DSP_CP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [2:0]       req_op,
  input  logic [CP_W-1:0]  req_cpnum,
  input  logic [CRN_W-1:0] req_crn,
  input  logic [CRM_W-1:0] req_crm,
  input  logic             req_priv,
  output logic             rsp_allow,
  output logic             rsp_undef,
  output logic [2:0]       rsp_tag
);

  localparam logic [CP_W-1:0] SYS_ID = CP_W'(SYS_CP);
  localparam logic [CP_W-1:0] DBG_ID = CP_W'(DBG_CP);
  localparam logic [CP_W-1:0] DSP_ID = CP_W'(DSP_CP);

  cp_op_e   op_d;
  reg_tag_e tag_d;
  logic     allow_d;
  verdict_t vd_nxt;
  verdict_t vd_q;
  logic     unused_crn;

  // CRn selects a register within a group but never changes the verdict.
  assign unused_crn = ^req_crn;
  assign op_d       = cp_op_e'(req_op);

  cpacc_classify #(
    .CP_W  (CP_W),
    .CRM_W (CRM_W),
    .SYS_CP(SYS_CP),
    .DBG_CP(DBG_CP),
    .DSP_CP(DSP_CP)
  ) u_classify (
    .cpnum(req_cpnum),
    .crm  (req_crm),
    .tag  (tag_d)
  );

  cpacc_rules u_rules (
    .op   (op_d),
    .tag  (tag_d),
    .priv (req_priv),
    .allow(allow_d)
  );

  always_comb begin
    vd_nxt = '0;
    if (req_vld) begin
      vd_nxt.allow = allow_d;
      vd_nxt.undef = !allow_d;
      vd_nxt.tag   = tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q <= '0;
    end else begin
      vd_q <= vd_nxt;
    end
  end

  assign rsp_allow = vd_q.allow;
  assign rsp_undef = vd_q.undef;
  assign rsp_tag   = vd_q.tag;

  // R9: a strobe yields exactly one verdict bit on the next cycle
  a_r9_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (rsp_allow ^ rsp_undef));

  // R9: no strobe leaves every output at zero on the next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_allow && !rsp_undef && rsp_tag == 3'd0));

  // R2: user-mode system-control access traps
  a_r2_user_sys: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_priv && req_cpnum == SYS_ID) |=> (rsp_undef && rsp_tag == 3'd0));

  // R5: user-mode debug/power access traps
  a_r5_user_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_priv && req_cpnum == DBG_ID) |=> rsp_undef);

  // R4: load/store to the performance monitor group traps
  a_r4_pmu_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cpnum == DBG_ID && req_crm != '0 &&
     (req_op == 3'd2 || req_op == 3'd3)) |=> (rsp_undef && rsp_tag == 3'd1));

  // R6: data-processing and dual transfers never reach coprocessor 14 or 15
  a_r6_no_dual: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_cpnum == DBG_ID || req_cpnum == SYS_ID) &&
     (req_op == 3'd4 || req_op == 3'd5 || req_op == 3'd6)) |=> rsp_undef);

  // R8: undefined coprocessor numbers trap with the none tag
  a_r8_unknown_cp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_cpnum != SYS_ID && req_cpnum != DBG_ID && req_cpnum != DSP_ID)
    |=> (rsp_undef && rsp_tag == 3'd7));

endmodule

// File: tb/cpacc_gate_bench.sv
`timescale 1ns/1ps
module cpacc_gate_bench;

  logic       clk;
  logic       rst_n;
  logic       req_vld;
  logic [2:0] req_op;
  logic [3:0] req_cpnum;
  logic [3:0] req_crn;
  logic [3:0] req_crm;
  logic       req_priv;
  logic       rsp_allow;
  logic       rsp_undef;
  logic [2:0] rsp_tag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cpacc_gate u_cpacc_gate (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .req_cpnum(req_cpnum), .req_crn(req_crn), .req_crm(req_crm),
    .req_priv(req_priv), .rsp_allow(rsp_allow), .rsp_undef(rsp_undef),
    .rsp_tag(rsp_tag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector fields: op[23:21] cp[20:17] crm[16:13] crn[12:9] priv[8] allow[7] tag[6:4] req[3:0]
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 4'd15, 4'd0,  4'd1,  1'b1, 1'b1, 3'd0, 4'd1},  // R1
    {3'd1, 4'd15, 4'd3,  4'd7,  1'b1, 1'b1, 3'd0, 4'd1},  // R1
    {3'd0, 4'd15, 4'd0,  4'd1,  1'b0, 1'b0, 3'd0, 4'd2},  // R2 user
    {3'd2, 4'd15, 4'd0,  4'd0,  1'b1, 1'b0, 3'd0, 4'd2},  // R2 LDC
    {3'd3, 4'd15, 4'd0,  4'd0,  1'b1, 1'b0, 3'd0, 4'd2},  // R2 STC
    {3'd0, 4'd14, 4'd0,  4'd2,  1'b1, 1'b1, 3'd2, 4'd3},  // R3
    {3'd1, 4'd14, 4'd1,  4'd2,  1'b1, 1'b1, 3'd1, 4'd3},  // R3 pmu
    {3'd2, 4'd14, 4'd0,  4'd0,  1'b1, 1'b1, 3'd2, 4'd4},  // R4
    {3'd3, 4'd14, 4'd0,  4'd5,  1'b1, 1'b1, 3'd2, 4'd4},  // R4
    {3'd2, 4'd14, 4'd2,  4'd0,  1'b1, 1'b0, 3'd1, 4'd4},  // R4 blocked
    {3'd3, 4'd14, 4'd15, 4'd0,  1'b1, 1'b0, 3'd1, 4'd4},  // R4 blocked
    {3'd0, 4'd14, 4'd0,  4'd0,  1'b0, 1'b0, 3'd2, 4'd5},  // R5
    {3'd2, 4'd14, 4'd0,  4'd0,  1'b0, 1'b0, 3'd2, 4'd5},  // R5
    {3'd2, 4'd14, 4'd4,  4'd0,  1'b0, 1'b0, 3'd1, 4'd5},  // R5 with R4 overlap
    {3'd4, 4'd15, 4'd0,  4'd0,  1'b1, 1'b0, 3'd0, 4'd6},  // R6
    {3'd5, 4'd14, 4'd0,  4'd0,  1'b1, 1'b0, 3'd2, 4'd6},  // R6
    {3'd6, 4'd15, 4'd0,  4'd0,  1'b1, 1'b0, 3'd0, 4'd6},  // R6
    {3'd4, 4'd14, 4'd0,  4'd0,  1'b1, 1'b0, 3'd2, 4'd6},  // R6
    {3'd0, 4'd0,  4'd0,  4'd0,  1'b0, 1'b1, 3'd3, 4'd7},  // R7
    {3'd5, 4'd0,  4'd0,  4'd0,  1'b0, 1'b1, 3'd3, 4'd7},  // R7
    {3'd6, 4'd0,  4'd9,  4'd0,  1'b1, 1'b1, 3'd3, 4'd7},  // R7
    {3'd2, 4'd0,  4'd0,  4'd0,  1'b1, 1'b0, 3'd3, 4'd7},  // R7
    {3'd4, 4'd0,  4'd0,  4'd0,  1'b1, 1'b0, 3'd3, 4'd7},  // R7
    {3'd0, 4'd7,  4'd0,  4'd0,  1'b1, 1'b0, 3'd7, 4'd8},  // R8
    {3'd1, 4'd1,  4'd0,  4'd0,  1'b1, 1'b0, 3'd7, 4'd8},  // R8
    {3'd7, 4'd15, 4'd0,  4'd0,  1'b1, 1'b0, 3'd0, 4'd8},  // R8 reserved class
    {3'd0, 4'd15, 4'd0,  4'd15, 1'b1, 1'b1, 3'd0, 4'd11}  // R11 CRn extreme
  };

  task automatic check(input string tag, input logic a, input logic u,
                       input logic [2:0] t);
    checks++;
    if (rsp_allow !== a || rsp_undef !== u || rsp_tag !== t) begin
      errors++;
      $display("FAIL %s: got allow=%0b undef=%0b tag=%0d, expected allow=%0b undef=%0b tag=%0d",
               tag, rsp_allow, rsp_undef, rsp_tag, a, u, t);
    end
  endtask

  task automatic drive(input logic [23:0] v);
    req_vld   = 1'b1;
    req_op    = v[23:21];
    req_cpnum = v[20:17];
    req_crm   = v[16:13];
    req_crn   = v[12:9];
    req_priv  = v[8];
  endtask

  task automatic idle();
    req_vld = 1'b0; req_op = '0; req_cpnum = '0; req_crn = '0;
    req_crm = '0; req_priv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
      end
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    req_vld = 1'b1; req_cpnum = 4'd15; req_priv = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset holds outputs low", 1'b0, 1'b0, 3'd0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", 1'b0, 1'b0, 3'd0);

    // Table walk, each vector isolated by an idle cycle
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      idle();
      check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][7], !VEC[i][7], VEC[i][6:4]);
      @(negedge clk);
      check($sformatf("R9 clear after vector %0d", i), 1'b0, 1'b0, 3'd0);
    end

    // R11: same request with every CRn value gives the same verdict
    for (int c = 0; c < 16; c++) begin
      drive({3'd3, 4'd14, 4'd0, c[3:0], 1'b1, 1'b0, 3'd0, 4'd0});
      @(negedge clk);
      check($sformatf("R11 crn=%0d", c), 1'b1, 1'b0, 3'd2);
    end
    idle();
    @(negedge clk);

    // R9: back-to-back strobes with opposite verdicts, then idle
    drive({3'd0, 4'd15, 4'd0, 4'd0, 1'b1, 1'b0, 3'd0, 4'd0});
    @(negedge clk);
    check("R9 b2b first (allow)", 1'b1, 1'b0, 3'd0);
    drive({3'd2, 4'd14, 4'd1, 4'd0, 1'b1, 1'b0, 3'd0, 4'd0});
    @(negedge clk);
    check("R9 b2b second (R4 undef)", 1'b0, 1'b1, 3'd1);
    drive({3'd1, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 3'd0, 4'd0});
    @(negedge clk);
    idle();
    check("R9 b2b third (R7 allow)", 1'b1, 1'b0, 3'd3);
    @(negedge clk);
    check("R9 b2b idle clears", 1'b0, 1'b0, 3'd0);

    // R10: asynchronous reset while a verdict is held
    drive({3'd0, 4'd14, 4'd0, 4'd0, 1'b1, 1'b0, 3'd0, 4'd0});
    @(negedge clk);
    check("R3 before reset", 1'b1, 1'b0, 3'd2);
    #1 rst_n = 1'b0;
    #0.5;
    check("R10 async reset clears", 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset release", 1'b0, 1'b0, 3'd0);

    finish_run();
  end

endmodule